// File: doc/BRIEF.md
# Operand-Qualified Load-Use Stall Detector

This block sits beside the decode stage of a five-stage 32-bit integer pipeline and decides, within one cycle, whether the instruction now in decode has to wait for an older instruction. It first decodes the opcode, and for system instructions the funct3 field, of the decode-stage instruction word. From these it works out which source register fields the instruction really reads. Only those fields are compared against the destination registers of the instructions in the execute and memory stages. Bits that hold immediate data in the source-field positions therefore never cause a stall.

A conflict with the execute stage counts when that stage holds a load, or when the decode instruction is a jump. In that case the jump needs its operand at once, because no forwarding path reaches it. A conflict with the memory stage counts only for a jump in decode against a load in memory. On a conflict the block raises its program-counter stall, fetch stall and decode flush outputs together. This holds fetch and turns the decode slot into a single bubble. The outputs are purely combinational. The surrounding pipeline registers them where it needs to.

Top module: `ld_hazard_unit`

## Requirements
- R1: The block reads the opcode from instruction bits [6:0], funct3 from bits [14:12], the first source field from bits [19:15] and the second source field from bits [24:20]. It ignores all other bits.
- R2: The first source field counts as unused for opcodes 1101111 (JAL), 0110111 (LUI), 0010111 (AUIPC) and 0001111 (MISC-MEM/FENCE). For every opcode not named in R2 or R3 it counts as used.
- R3: For opcode 1110011 (SYSTEM), the first source field is unused when funct3 is 000, 101, 110 or 111. It is used when funct3 is 001, 010 or 011.
- R4: The second source field counts as used only for opcodes 0110011 (register ALU), 0100011 (store) and 1100011 (branch).
- R5: An execute-stage conflict exists when (the execute load flag is high or the decode jump flag is high), the execute destination is nonzero, and a used source field equals that destination.
- R6: A destination of register 0 never causes a conflict in either stage.
- R7: A memory-stage conflict exists only when the decode jump flag is high, the memory load flag is high, the memory destination is nonzero, and a used source field equals it.
- R8: The program-counter stall, fetch stall and decode flush outputs are always equal to one another. They are high exactly when R5 or R7 reports a conflict.
- R9: With a load to register 16 in execute, neither of these decode instructions produces a stall: a load whose immediate low bits equal 16, or an add that reads registers 2 and 3.
- R10: With a load to register 5 in execute, an add in decode that reads register 5 through either source field produces a stall.
- R11: The outputs follow the current inputs in the same cycle, with no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Raw instruction word in the decode stage |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| id_is_jump | input | 1 | Decode-stage instruction is a jump or branch needing operands now |
| pc_stall | output | 1 | Hold the program counter |
| fetch_stall | output | 1 | Hold the fetch/decode pipeline register |
| dec_flush | output | 1 | Replace the decode-stage instruction with a bubble |

## Verification
The checks assume the flags are consistent with the destination fields the pipeline supplies. They do not require a load flag to imply a nonzero destination, so register 0 is fed in with and without the flags raised. The stimulus applies every input change half a cycle away from the sampling point, so each combinational check sees settled values. Random stimulus draws opcodes only from the listed classes and keeps register indices within a small range. This makes source and destination matches frequent, and it also exercises immediate bits that happen to look like register numbers.

// File: rtl/ld_hazard_pkg.sv
package ld_hazard_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD    = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_OP      = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_STORE   = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH  = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL     = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR    = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI     = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC   = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_MISCMEM = 7'b0001111;
    localparam logic [OPC_W-1:0] OPC_SYSTEM  = 7'b1110011;

    // Which source fields the decode-stage instruction really reads
    typedef struct packed {
        logic use_a;
        logic use_b;
    } src_use_t;

    // Combined hazard view computed each cycle
    typedef struct packed {
        logic ex_hit;
        logic mem_hit;
        logic stall;
    } hz_state_t;

endpackage

// File: rtl/src_use_decode.sv
module src_use_decode
    import ld_hazard_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    output src_use_t         use_o
);
    src_use_t use_d;

    always_comb begin
        use_d = '{use_a: 1'b1, use_b: 1'b0};
        unique case (opcode)
            OPC_JAL, OPC_LUI, OPC_AUIPC, OPC_MISCMEM: use_d.use_a = 1'b0;
            OPC_SYSTEM: begin
                // immediate CSR forms and environment calls carry no register
                if (funct3 == 3'b000 || funct3 == 3'b101 ||
                    funct3 == 3'b110 || funct3 == 3'b111)
                    use_d.use_a = 1'b0;
            end
            OPC_OP, OPC_STORE, OPC_BRANCH: use_d.use_b = 1'b1;
            default: ;
        endcase
    end

    assign use_o = use_d;
endmodule

// File: rtl/stage_match.sv
module stage_match #(
    parameter int REG_W = 5
) (
    input  logic             qual,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             use_a,
    input  logic             use_b,
    output logic             hit
);
    logic dst_live;
    logic a_eq;
    logic b_eq;

    always_comb begin
        dst_live = |dst;
        a_eq     = use_a && (src_a == dst);
        b_eq     = use_b && (src_b == dst);
        hit      = qual && dst_live && (a_eq || b_eq);
    end
endmodule

// File: rtl/ld_hazard_unit.sv
module ld_hazard_unit
    import ld_hazard_pkg::*;
#(
    parameter int N_OLDER = 2
) (
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [REG_W-1:0]   ex_rd,
    input  logic               ex_is_load,
    input  logic [REG_W-1:0]   mem_rd,
    input  logic               mem_is_load,
    input  logic               id_is_jump,
    output logic               pc_stall,
    output logic               fetch_stall,
    output logic               dec_flush
);
    localparam int SRC_A_LSB = 15;
    localparam int SRC_B_LSB = 20;
    localparam int F3_LSB    = 12;

    logic [OPC_W-1:0] opc;
    logic [F3_W-1:0]  f3;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             unused_bits;
    src_use_t         use_s;

    assign opc         = id_instr[OPC_W-1:0];
    assign f3          = id_instr[F3_LSB +: F3_W];
    assign src_a       = id_instr[SRC_A_LSB +: REG_W];
    assign src_b       = id_instr[SRC_B_LSB +: REG_W];
    assign unused_bits = ^{id_instr[INSTR_W-1:SRC_B_LSB+REG_W],
                           id_instr[F3_LSB-1:OPC_W]};

    src_use_decode u_dec (
        .opcode (opc),
        .funct3 (f3),
        .use_o  (use_s)
    );

    // index 0: execute stage, index 1: memory stage
    logic [N_OLDER-1:0]            qual_v;
    logic [N_OLDER-1:0][REG_W-1:0] dst_v;
    logic [N_OLDER-1:0]            hit_v;

    always_comb begin
        qual_v    = '0;
        dst_v     = '0;
        qual_v[0] = ex_is_load || id_is_jump;
        dst_v[0]  = ex_rd;
        if (N_OLDER > 1) begin
            qual_v[N_OLDER-1] = id_is_jump && mem_is_load;
            dst_v[N_OLDER-1]  = mem_rd;
        end
    end

    for (genvar g = 0; g < N_OLDER; g++) begin : g_stage
        stage_match #(.REG_W(REG_W)) u_match (
            .qual  (qual_v[g]),
            .dst   (dst_v[g]),
            .src_a (src_a),
            .src_b (src_b),
            .use_a (use_s.use_a),
            .use_b (use_s.use_b),
            .hit   (hit_v[g])
        );
    end

    hz_state_t hz_d;

    always_comb begin
        hz_d         = '0;
        hz_d.ex_hit  = hit_v[0];
        hz_d.mem_hit = hit_v[N_OLDER-1] && (N_OLDER > 1);
        hz_d.stall   = |hit_v;
    end

    assign pc_stall    = hz_d.stall;
    assign fetch_stall = hz_d.stall;
    assign dec_flush   = hz_d.stall;
endmodule

// File: rtl/ld_hazard_chk.sv
module ld_hazard_chk
    import ld_hazard_pkg::*;
(
    input logic [INSTR_W-1:0] id_instr,
    input logic [REG_W-1:0]   ex_rd,
    input logic               ex_is_load,
    input logic [REG_W-1:0]   mem_rd,
    input logic               mem_is_load,
    input logic               id_is_jump,
    input logic               pc_stall,
    input logic               fetch_stall,
    input logic               dec_flush
);
    logic [OPC_W-1:0] c_opc;
    logic [REG_W-1:0] c_a;
    logic [REG_W-1:0] c_b;
    logic             any_field_match;

    always_comb begin
        c_opc = id_instr[6:0];
        c_a   = id_instr[19:15];
        c_b   = id_instr[24:20];
        any_field_match = (c_a == ex_rd) || (c_b == ex_rd) ||
                          (c_a == mem_rd) || (c_b == mem_rd);

        // R8
        outs_equal_chk: assert ((pc_stall == fetch_stall) && (fetch_stall == dec_flush))
            else $error("stall outputs disagree");

        // R7
        no_qual_chk: assert (ex_is_load || id_is_jump || !pc_stall)
            else $error("stall without load in execute or jump in decode");

        // R6
        zero_dst_chk: assert (!pc_stall || (ex_rd != '0) || (mem_rd != '0))
            else $error("stall against register 0");

        // R5
        field_match_chk: assert (!pc_stall || any_field_match)
            else $error("stall without any source field match");

        // R2
        no_src_chk: assert (!pc_stall || !(c_opc == OPC_JAL || c_opc == OPC_LUI ||
                                           c_opc == OPC_AUIPC || c_opc == OPC_MISCMEM))
            else $error("stall for an instruction with no register sources");

        // R4
        imm_b_chk: assert (!pc_stall || !(c_opc == OPC_OPIMM || c_opc == OPC_LOAD ||
                                          c_opc == OPC_JALR) ||
                           (c_a == ex_rd) || (c_a == mem_rd))
            else $error("stall from immediate bits in the second source field");
    end
endmodule

bind ld_hazard_unit ld_hazard_chk u_chk (
    .id_instr    (id_instr),
    .ex_rd       (ex_rd),
    .ex_is_load  (ex_is_load),
    .mem_rd      (mem_rd),
    .mem_is_load (mem_is_load),
    .id_is_jump  (id_is_jump),
    .pc_stall    (pc_stall),
    .fetch_stall (fetch_stall),
    .dec_flush   (dec_flush)
);

// File: tb/tb_ld_hazard_unit.sv
module tb_ld_hazard_unit;
    logic        clk = 1'b0;
    logic [31:0] id_instr;
    logic [4:0]  ex_rd;
    logic        ex_is_load;
    logic [4:0]  mem_rd;
    logic        mem_is_load;
    logic        id_is_jump;
    logic        pc_stall;
    logic        fetch_stall;
    logic        dec_flush;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ld_hazard_unit dut (
        .id_instr    (id_instr),
        .ex_rd       (ex_rd),
        .ex_is_load  (ex_is_load),
        .mem_rd      (mem_rd),
        .mem_is_load (mem_is_load),
        .id_is_jump  (id_is_jump),
        .pc_stall    (pc_stall),
        .fetch_stall (fetch_stall),
        .dec_flush   (dec_flush)
    );

    function automatic logic [31:0] enc(int op, int rd, int f3, int a, int b, int f7);
        logic [31:0] w;
        w = {f7[6:0], b[4:0], a[4:0], f3[2:0], rd[4:0], op[6:0]};
        return w;
    endfunction

    // behavioural model of the usage and stall rules
    function automatic bit model_stall(logic [31:0] w, int erd, bit eld, int mrd, bit mld, bit jmp);
        int op; int f3; int a; int b;
        bit ua; bit ub; bit ex_c; bit mem_c;
        int no_a_ops[$] = '{'h6F, 'h37, 'h17, 'h0F};
        int b_ops[$]    = '{'h33, 'h23, 'h63};
        op = int'(w[6:0]); f3 = int'(w[14:12]);
        a  = int'(w[19:15]); b = int'(w[24:20]);
        ua = 1'b1;
        foreach (no_a_ops[i]) if (no_a_ops[i] == op) ua = 1'b0;
        if (op == 'h73 && (f3 == 0 || f3 >= 5)) ua = 1'b0;
        ub = 1'b0;
        foreach (b_ops[i]) if (b_ops[i] == op) ub = 1'b1;
        ex_c  = (eld || jmp) && erd != 0 && ((ua && a == erd) || (ub && b == erd));
        mem_c = jmp && mld && mrd != 0 && ((ua && a == mrd) || (ub && b == mrd));
        return ex_c || mem_c;
    endfunction

    task automatic drive(logic [31:0] w, int erd, bit eld, int mrd, bit mld, bit jmp);
        @(posedge clk);
        id_instr = w; ex_rd = erd[4:0]; ex_is_load = eld;
        mem_rd = mrd[4:0]; mem_is_load = mld; id_is_jump = jmp;
        @(negedge clk);
    endtask

    task automatic check(string req, bit exp);
        checks++;
        if (pc_stall !== exp || fetch_stall !== exp || dec_flush !== exp) begin
            errors++;
            $display("FAIL %s: got pc=%b fetch=%b flush=%b expected %b",
                     req, pc_stall, fetch_stall, dec_flush, exp);
        end
    endtask

    task automatic step(string req, logic [31:0] w, int erd, bit eld, int mrd, bit mld, bit jmp, bit exp);
        drive(w, erd, eld, mrd, mld, jmp);
        check(req, exp);
        // model cross-check of the directed expectation
        check({req, " model"}, model_stall(w, erd, eld, mrd, mld, jmp));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ops[12] = '{'h03, 'h13, 'h33, 'h23, 'h63, 'h6F, 'h67, 'h37, 'h17, 'h0F, 'h73, 'h00};
        id_instr = '0; ex_rd = '0; ex_is_load = 1'b0;
        mem_rd = '0; mem_is_load = 1'b0; id_is_jump = 1'b0;
        @(negedge clk);
        check("R8 idle", 1'b0);

        // R10 true dependencies through each field
        step("R10 add rs1", enc('h33, 1, 0, 5, 6, 0), 5, 1, 0, 0, 0, 1'b1);
        step("R10 add rs2", enc('h33, 1, 0, 6, 5, 0), 5, 1, 0, 0, 0, 1'b1);
        // R9 false stall cases
        step("R9 load imm 16", enc('h03, 10, 2, 15, 16, 0), 16, 1, 0, 0, 0, 1'b0);
        step("R9 add x2 x3", enc('h33, 1, 0, 2, 3, 0), 16, 1, 0, 0, 0, 1'b0);
        // R6 register 0
        step("R6 ex x0", enc('h33, 0, 0, 0, 0, 0), 0, 1, 0, 1, 1, 1'b0);
        // R2 no first source
        step("R2 lui", enc('h37, 1, 0, 5, 5, 0), 5, 1, 0, 0, 0, 1'b0);
        step("R2 jal", enc('h6F, 1, 0, 5, 5, 0), 5, 1, 0, 0, 1, 1'b0);
        step("R2 auipc", enc('h17, 1, 0, 5, 5, 0), 5, 1, 0, 0, 0, 1'b0);
        step("R2 fence", enc('h0F, 0, 0, 5, 5, 0), 5, 1, 0, 0, 0, 1'b0);
        // R3 system forms
        step("R3 csrrwi", enc('h73, 1, 5, 7, 7, 0), 7, 1, 0, 0, 0, 1'b0);
        step("R3 csrrci", enc('h73, 1, 7, 7, 7, 0), 7, 1, 0, 0, 0, 1'b0);
        step("R3 csrrw", enc('h73, 1, 1, 7, 7, 0), 7, 1, 0, 0, 0, 1'b1);
        step("R3 ecall", enc('h73, 0, 0, 7, 7, 0), 7, 1, 0, 0, 0, 1'b0);
        // R4 second field usage
        step("R4 store", enc('h23, 4, 2, 1, 9, 0), 9, 1, 0, 0, 0, 1'b1);
        step("R4 branch", enc('h63, 4, 1, 1, 9, 0), 9, 1, 0, 0, 0, 1'b1);
        step("R4 opimm", enc('h13, 4, 0, 1, 9, 0), 9, 1, 0, 0, 0, 1'b0);
        step("R4 jalr", enc('h67, 1, 0, 2, 9, 0), 9, 1, 0, 0, 1, 1'b0);
        // R1 bits outside the fields are ignored
        step("R1 upper bits", enc('h13, 31, 7, 1, 9, 127), 31, 1, 0, 0, 0, 1'b0);
        // R5 jump qualifies execute without a load
        step("R5 jump ex", enc('h67, 1, 0, 8, 0, 0), 8, 0, 0, 0, 1, 1'b1);
        step("R5 no qual", enc('h67, 1, 0, 8, 0, 0), 8, 0, 0, 0, 0, 1'b0);
        // R7 memory stage
        step("R7 jump mem load", enc('h67, 1, 0, 4, 0, 0), 0, 0, 4, 1, 1, 1'b1);
        step("R7 no jump", enc('h67, 1, 0, 4, 0, 0), 0, 0, 4, 1, 0, 1'b0);
        step("R7 mem not load", enc('h67, 1, 0, 4, 0, 0), 0, 0, 4, 0, 1, 1'b0);
        step("R7 mem x0", enc('h63, 1, 0, 0, 0, 0), 0, 0, 0, 1, 1, 1'b0);
        // R11 immediate response when inputs change back
        step("R11 same cycle", enc('h33, 1, 0, 6, 5, 0), 5, 1, 0, 0, 0, 1'b1);

        // random phase, compared with the model every clock (R5 R7 R8)
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            int erd; int mrd; bit eld; bit mld; bit jmp;
            w = enc(ops[$urandom_range(11)], $urandom_range(7), $urandom_range(7),
                    $urandom_range(7), $urandom_range(7), $urandom_range(127));
            w[31:25] = 7'($urandom);
            erd = $urandom_range(7); mrd = $urandom_range(7);
            eld = 1'($urandom); mld = 1'($urandom); jmp = 1'($urandom);
            drive(w, erd, eld, mrd, mld, jmp);
            check("R5 R7 random", model_stall(w, erd, eld, mrd, mld, jmp));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule